// File: doc/BRIEF.md
# Interleaved DRAM Range Decoder

This block takes a 40-bit physical address and a read/write flag, and works out which of eight programmable DRAM windows claims the access. Each window has a start register and an end register, loaded through a plain write port that takes an 8-bit offset and 32-bit data. A window claims an address only when all three of these hold:

- the address's upper bits fall inside the window;
- the window allows the access type;
- any address bits the window interleaves on match the window's select value.

A node-level request router uses the block to pick the destination node for a memory access. It gives a request on one cycle and reads the hit flag, destination node and winning window index on the next cycle. When several windows claim an address, the lowest-numbered window wins. When none claims it, all three outputs are zero.

Top module: `dram_range_decoder`

## Requirements
- R1: The start register of window i is written at offset 0x40+8*i and its end register at offset 0x44+8*i, for i = 0..7. A write to any other offset (including misaligned ones such as 0x42) changes no window.
- R2: Start register fields: bit 0 = read allowed, bit 1 = write allowed, bits 10:8 = interleave mode, bits 31:16 = address bits 39:24 of the window start.
- R3: End register fields: bits 2:0 = destination node (0..7), bits 10:8 = interleave select value, bits 31:16 = address bits 39:24 of the window end.
- R4: A window's address test passes when start <= A[39:24] <= end, with both bounds inclusive.
- R5: A read (req_write=0) needs the read-allowed bit of the window set. A write (req_write=1) needs the write-allowed bit set.
- R6: Interleave mode 001 requires A[12] = select bit 0. Mode 011 requires A[12] = select bit 0 and A[14] = select bit 2. Mode 111 requires A[14:12] = select[2:0]. Mode 000 makes no interleave test.
- R7: Interleave modes 010, 100, 101 and 110 behave like 000: the interleave bits are not tested.
- R8: When several windows claim an address, the lowest index wins. rsp_range carries that index and rsp_node carries that window's node.
- R9: When no window claims the request, or req_valid is low, rsp_hit, rsp_node and rsp_range are all 0.
- R10: The outputs reflect the request sampled at a rising clock edge and hold that value until the next edge.
- R11: A synchronous reset clears every window to start 0, end 0 and no access allowed, and it clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write offset |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Lookup request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 40 | Physical address to decode |
| rsp_hit | output | 1 | A window claimed the previous request |
| rsp_node | output | 3 | Destination node of the winning window |
| rsp_range | output | 3 | Index of the winning window |

## Verification
A corrupted window register stays hidden until a request lands in that window. It then shows up one clock later as a wrong hit flag, node or index. For that reason the stimulus probes each window at its inclusive edges, just outside them, and with every interleave bit pattern that separates one mode from another. A fault in the priority logic only appears when windows overlap, so overlapping windows are programmed deliberately, and one is later disabled to move the winner. A write at a misaligned offset, followed by a lookup, checks at the ports that offset decoding is exact.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
    localparam int ADDR_W     = 40;
    localparam int NUM_RANGES = 8;
    localparam int IDX_W      = $clog2(NUM_RANGES);
    localparam int NODE_W     = 3;
    localparam int TAG_W      = 16;
    localparam int TAG_LSB    = ADDR_W - TAG_W;
    localparam int ILV_W      = 3;
    localparam int ILV_LSB    = 12;
    localparam int CFG_AW     = 8;
    localparam int CFG_DW     = 32;
    localparam int REG_BASE   = 'h40;
    localparam int REG_STRIDE = 8;
    localparam int END_DELTA  = 4;

    typedef struct packed {
        logic              rd_ok;
        logic              wr_ok;
        logic [ILV_W-1:0]  ilv_mode;
        logic [TAG_W-1:0]  lo;
    } win_start_t;

    typedef struct packed {
        logic [NODE_W-1:0] node;
        logic [ILV_W-1:0]  ilv_sel;
        logic [TAG_W-1:0]  hi;
    } win_end_t;

    typedef struct packed {
        logic              hit;
        logic [NODE_W-1:0] node;
        logic [IDX_W-1:0]  idx;
    } lookup_t;

    function automatic win_start_t unpack_start(input logic [CFG_DW-1:0] w);
        win_start_t s;
        s.rd_ok    = w[0];
        s.wr_ok    = w[1];
        s.ilv_mode = w[10:8];
        s.lo       = w[31:16];
        return s;
    endfunction

    function automatic win_end_t unpack_end(input logic [CFG_DW-1:0] w);
        win_end_t e;
        e.node    = w[2:0];
        e.ilv_sel = w[10:8];
        e.hi      = w[31:16];
        return e;
    endfunction

    // Which of A[14:12] take part in the interleave test; unlisted modes test none.
    function automatic logic [ILV_W-1:0] ilv_mask(input logic [ILV_W-1:0] mode);
        case (mode)
            3'b001:  return 3'b001;
            3'b011:  return 3'b101;
            3'b111:  return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
        return a[TAG_LSB +: TAG_W];
    endfunction

    function automatic logic [ILV_W-1:0] addr_ilv(input logic [ADDR_W-1:0] a);
        return a[ILV_LSB +: ILV_W];
    endfunction
endpackage

// File: rtl/dram_range_regs.sv
module dram_range_regs
    import dram_dec_pkg::*;
#(
    parameter int N_WIN = NUM_RANGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output win_start_t        starts [N_WIN],
    output win_end_t          ends   [N_WIN]
);
    for (genvar i = 0; i < N_WIN; i++) begin : g_win
        localparam logic [CFG_AW-1:0] START_OFS = CFG_AW'(REG_BASE + REG_STRIDE * i);
        localparam logic [CFG_AW-1:0] END_OFS   = CFG_AW'(REG_BASE + REG_STRIDE * i + END_DELTA);

        always_ff @(posedge clk) begin
            if (rst) begin
                starts[i] <= '0;
                ends[i]   <= '0;
            end else if (cfg_we) begin
                if (cfg_addr == START_OFS) starts[i] <= unpack_start(cfg_wdata);
                if (cfg_addr == END_OFS)   ends[i]   <= unpack_end(cfg_wdata);
            end
        end
    end
endmodule

// File: rtl/dram_range_match.sv
module dram_range_match
    import dram_dec_pkg::*;
(
    input  logic              valid,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  win_start_t        start,
    input  win_end_t          stop,
    output logic              claim
);
    logic [TAG_W-1:0] tag;
    logic [ILV_W-1:0] ilv_bits;
    logic             in_window;
    logic             access_ok;
    logic             ilv_ok;

    always_comb begin
        tag       = addr_tag(addr);
        ilv_bits  = addr_ilv(addr);
        in_window = (tag >= start.lo) && (tag <= stop.hi);
        access_ok = is_write ? start.wr_ok : start.rd_ok;
        ilv_ok    = ((ilv_bits ^ stop.ilv_sel) & ilv_mask(start.ilv_mode)) == '0;
        claim     = valid && in_window && access_ok && ilv_ok;
    end
endmodule

// File: rtl/dram_range_prio.sv
module dram_range_prio
    import dram_dec_pkg::*;
#(
    parameter int N_WIN = NUM_RANGES
) (
    input  logic [N_WIN-1:0]  claims,
    input  logic [NODE_W-1:0] nodes [N_WIN],
    output lookup_t           result
);
    always_comb begin
        result = '0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (claims[i]) begin
                result.hit  = 1'b1;
                result.node = nodes[i];
                result.idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dram_range_decoder.sv
module dram_range_decoder
    import dram_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_hit,
    output logic [NODE_W-1:0] rsp_node,
    output logic [IDX_W-1:0]  rsp_range
);
    win_start_t              starts [NUM_RANGES];
    win_end_t                ends   [NUM_RANGES];
    logic [NUM_RANGES-1:0]   claims;
    logic [NODE_W-1:0]       nodes  [NUM_RANGES];
    lookup_t                 res_d;
    lookup_t                 res_q;

    dram_range_regs #(.N_WIN(NUM_RANGES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .starts    (starts),
        .ends      (ends)
    );

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_match
        dram_range_match u_match (
            .valid    (req_valid),
            .is_write (req_write),
            .addr     (req_addr),
            .start    (starts[i]),
            .stop     (ends[i]),
            .claim    (claims[i])
        );
        assign nodes[i] = ends[i].node;
    end

    dram_range_prio #(.N_WIN(NUM_RANGES)) u_prio (
        .claims (claims),
        .nodes  (nodes),
        .result (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign rsp_hit   = res_q.hit;
    assign rsp_node  = res_q.node;
    assign rsp_range = res_q.idx;
endmodule

// File: rtl/dram_range_decoder_chk.sv
module dram_range_decoder_chk
    import dram_dec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              rsp_hit,
    input logic [NODE_W-1:0] rsp_node,
    input logic [IDX_W-1:0]  rsp_range
);
    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_node == '0 && rsp_range == '0));

    // R9
    idle_miss_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_hit);

    // R10
    hit_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> $past(req_valid));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_hit && rsp_node == '0 && rsp_range == '0));
endmodule

bind dram_range_decoder dram_range_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rsp_hit   (rsp_hit),
    .rsp_node  (rsp_node),
    .rsp_range (rsp_range)
);

// File: tb/dram_range_decoder_tb.sv
module dram_range_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [39:0] req_addr = '0;
    logic        rsp_hit;
    logic [2:0]  rsp_node;
    logic [2:0]  rsp_range;

    int checks = 0;
    int fails  = 0;
    logic [47:0] v;

    always #4 clk = ~clk;

    dram_range_decoder u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .rsp_hit(rsp_hit), .rsp_node(rsp_node),
        .rsp_range(rsp_range)
    );

    // {write, address, hit, node, window}
    localparam logic [47:0] VEC [16] = '{
        {1'b0, 40'h00_0000_0000, 1'b1, 3'd2, 3'd0},  // R4 lower bound of window 0
        {1'b1, 40'h00_3FFF_FFFF, 1'b1, 3'd2, 3'd0},  // R4 inclusive upper bound
        {1'b0, 40'h00_1500_0000, 1'b1, 3'd2, 3'd0},  // R8 overlap 0/5 -> 0
        {1'b0, 40'h00_4000_1000, 1'b1, 3'd5, 3'd1},  // R6 mode 001, A12=1
        {1'b1, 40'h00_4000_1000, 1'b0, 3'd0, 3'd0},  // R5 window 1 read-only
        {1'b0, 40'h00_4000_0000, 1'b1, 3'd6, 3'd2},  // R6 mode 011, A14=A12=0
        {1'b0, 40'h00_4000_2000, 1'b1, 3'd6, 3'd2},  // R6 mode 011 ignores A13
        {1'b0, 40'h00_7F00_4000, 1'b1, 3'd7, 3'd3},  // R6 mode 111, A14:12=100
        {1'b0, 40'h00_7F00_6000, 1'b0, 3'd0, 3'd0},  // R6 A13 breaks mode 111
        {1'b1, 40'h00_8012_3456, 1'b1, 3'd1, 3'd4},  // R7 reserved mode 010
        {1'b0, 40'h00_8000_0000, 1'b0, 3'd0, 3'd0},  // R5 window 4 write-only
        {1'b0, 40'h00_8100_0000, 1'b0, 3'd0, 3'd0},  // R4 above end
        {1'b0, 40'h00_9F00_0000, 1'b1, 3'd3, 3'd6},  // R3 node field
        {1'b0, 40'h00_8FFF_FFFF, 1'b0, 3'd0, 3'd0},  // R4 below start
        {1'b0, 40'h01_0000_0000, 1'b0, 3'd0, 3'd0},  // R2 upper tag bits
        {1'b1, 40'h00_9000_0000, 1'b1, 3'd3, 3'd6}   // R2 write allowed
    };

    task automatic check(input string tag, input logic eh, input logic [2:0] en,
                         input logic [2:0] er);
        checks++;
        if (rsp_hit !== eh || rsp_node !== en || rsp_range !== er) begin
            fails++;
            $display("FAIL %s: got hit=%0d node=%0d range=%0d expected hit=%0d node=%0d range=%0d",
                     tag, rsp_hit, rsp_node, rsp_range, eh, en, er);
        end
    endtask

    task automatic cfg_write(input logic [7:0] ofs, input logic [31:0] data);
        cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic wr, input logic [39:0] a);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 outputs in reset", 1'b0, 3'd0, 3'd0);
        rst = 1'b0;
        lookup(1'b0, 40'h00_0000_0000);
        check("R11 windows cleared", 1'b0, 3'd0, 3'd0);

        cfg_write(8'h40, 32'h0000_0003); cfg_write(8'h44, 32'h003F_0002);
        cfg_write(8'h48, 32'h0040_0101); cfg_write(8'h4C, 32'h007F_0105);
        cfg_write(8'h50, 32'h0040_0303); cfg_write(8'h54, 32'h007F_0006);
        cfg_write(8'h58, 32'h0040_0703); cfg_write(8'h5C, 32'h007F_0407);
        cfg_write(8'h60, 32'h0080_0202); cfg_write(8'h64, 32'h0080_0701);
        cfg_write(8'h68, 32'h0010_0003); cfg_write(8'h6C, 32'h0020_0004);
        cfg_write(8'h70, 32'h0090_0003); cfg_write(8'h74, 32'h009F_0003);

        for (int i = 0; i < 16; i++) begin
            v = VEC[i];
            lookup(v[47], v[46:7]);
            check($sformatf("vector %0d (R2-R8)", i), v[6], v[5:3], v[2:0]);
        end

        // R10: output holds until the next edge, then updates
        lookup(1'b0, 40'h00_9F00_0000);
        req_addr = 40'h00_0000_0000;
        #1 check("R10 hold before edge", 1'b1, 3'd3, 3'd6);
        @(negedge clk);
        check("R10 update after edge", 1'b1, 3'd2, 3'd0);

        // R9: no request means miss even for a claimed address
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 idle request", 1'b0, 3'd0, 3'd0);

        // R1: misaligned offset must not touch window 0
        cfg_write(8'h42, 32'h00A0_0003);
        lookup(1'b0, 40'h00_0000_0000);
        check("R1 misaligned write ignored", 1'b1, 3'd2, 3'd0);

        // R1: window 7 offsets, node 0 hit
        cfg_write(8'h78, 32'h00A0_0003); cfg_write(8'h7C, 32'h00A0_0000);
        lookup(1'b0, 40'h00_A012_0000);
        check("R1 window 7 programmed", 1'b1, 3'd0, 3'd7);

        // R8: disabling window 0 hands the overlap to window 5
        cfg_write(8'h40, 32'h0000_0000);
        lookup(1'b0, 40'h00_1500_0000);
        check("R8 next lowest wins", 1'b1, 3'd4, 3'd5);
        lookup(1'b0, 40'h00_0000_0000);
        check("R9 disabled window misses", 1'b0, 3'd0, 3'd0);

        // R11: reset in the middle clears windows
        req_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 outputs after reset", 1'b0, 3'd0, 3'd0);
        lookup(1'b0, 40'h00_9F00_0000);
        check("R11 window 6 cleared", 1'b0, 3'd0, 3'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule